// File: doc/BRIEF.md
# Serial Converter Frame Reader

This block is the host-side reader for a serial analog-to-digital converter. The converter sends a 19-bit frame on one data line. When a start request arrives, the reader pulls the converter's chip-select low. It then watches the data line, which stays high while a conversion is still running. Once the line drops low, the reader produces exactly 19 serial clock pulses from a divided system clock and samples the data line on each rising edge.

The frame arrives in this order:
- an end-of-conversion flag;
- one bit that is thrown away;
- a sign bit;
- a 16-bit code, most significant bit first.

After the last pulse the reader releases chip-select. It then offers the code, the sign and an overrange flag on a valid/ready output. The result stays on that output, unchanged, until the consumer accepts it. No new read begins before that, so back-pressure simply stalls the next conversion read.

If the data line never drops low within a set number of cycles, the reader gives up. It releases chip-select and raises an error flag.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, cs_n is 1 and sck, res_valid, timeout_err and conv_busy are all 0.
- R2: A start pulse while the reader is idle drives cs_n low in the following cycle. While cs_n is low before clocking begins and sdo is high, conv_busy is 1.
- R3: No sck edge occurs until sdo has been seen low under chip-select. sck stays low while the reader waits.
- R4: Each successful frame has exactly 19 rising sck edges while cs_n is low.
- R5: The bit sampled on the 1st rising edge is the end-of-conversion flag and is discarded, as is the bit on the 2nd edge. The 3rd bit becomes res_sign. The 4th to 19th bits become res_data[15] down to res_data[0].
- R6: Every high phase of sck lasts HALF system cycles, and so does every low phase between two rising edges.
- R7: After the 19th rising edge, sck falls after HALF cycles, then cs_n returns high and res_valid rises.
- R8: While res_valid is 1 and res_ready is 0, res_valid, res_data, res_sign and res_ovr hold their values. A cycle with both high accepts the result, and res_valid is 0 in the next cycle.
- R9: A start pulse is ignored while a read is in progress or a result is waiting: cs_n stays high while a result waits.
- R10: res_ovr is 1 exactly when the received code is a clamp code. The clamp codes are res_sign=1 with res_data=16'hFFFF, and res_sign=0 with res_data=16'h0000.
- R11: If sdo stays high for TMO_CYC cycles of waiting, cs_n returns high and timeout_err becomes 1 without any result. The next accepted start clears timeout_err.
- R12: sck is low whenever cs_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to read one frame |
| cs_n | output | 1 | Converter chip-select, active low |
| sck | output | 1 | Serial clock to the converter, idles low |
| sdo | input | 1 | Serial data from the converter |
| conv_busy | output | 1 | Converter reports a conversion still running |
| timeout_err | output | 1 | Wait for end of conversion expired |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts the result |
| res_data | output | DW | Conversion code |
| res_sign | output | 1 | Sign bit of the frame |
| res_ovr | output | 1 | Code equals a clamp code |

## Verification
The bench builds the reader with HALF=3, an odd half-period, so the phase counter wraps at a value that is not a power of two and every phase length is checked against 3. TMO_CYC is set to 300, which keeps the timeout within reach. With that value the bench can also run one conversion just under the limit, which must succeed, and one well beyond it, which must abort. A converter model in the bench changes its data on falling sck edges and uses random conversion delays. Mixed with these are directed clamp codes and long back-pressure holds.

// File: rtl/afr_pkg.sv
package afr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_CLK,
    ST_HOLD
  } afr_state_e;
endpackage

// File: rtl/afr_sck_gen.sv
module afr_sck_gen #(
  parameter int HALF   = 4,
  parameter int NPULSE = 19
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic sck_o,
  output logic rise_o,
  output logic done_o
);
  localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int CW = $clog2(NPULSE + 1);

  logic [HW-1:0] hcnt;
  logic [CW-1:0] nrise;
  logic          sck_q;
  logic          tick;

  assign tick   = (hcnt == HW'(HALF - 1));
  assign rise_o = en && tick && !sck_q && (nrise != CW'(NPULSE));
  assign done_o = en && !sck_q && (nrise == CW'(NPULSE));
  assign sck_o  = sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt  <= '0;
      nrise <= '0;
      sck_q <= 1'b0;
    end else if (!en) begin
      hcnt  <= '0;
      nrise <= '0;
      sck_q <= 1'b0;
    end else begin
      if (tick) hcnt <= '0;
      else      hcnt <= hcnt + 1'b1;
      if (tick) begin
        if (sck_q) begin
          sck_q <= 1'b0;
        end else if (rise_o) begin
          sck_q <= 1'b1;
          nrise <= nrise + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/afr_shift.sv
module afr_shift #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (cap) q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/afr_tmo.sv
module afr_tmo #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire_o
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  assign expire_o = run && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (!run)      cnt <= '0;
    else if (!expire_o) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
  parameter int HALF    = 4,
  parameter int TMO_CYC = 100000,
  parameter int DW      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          cs_n,
  output logic          sck,
  input  logic          sdo,
  output logic          conv_busy,
  output logic          timeout_err,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [DW-1:0] res_data,
  output logic          res_sign,
  output logic          res_ovr
);
  import afr_pkg::*;

  localparam int NB = DW + 3;
  localparam int KW = DW + 1;

  afr_state_e    state;
  logic          cs_q, err_q, sign_q, ovr_q;
  logic [DW-1:0] data_q;
  logic          clk_en, rise, done, tmo_exp;
  logic [KW-1:0] keep;

  assign clk_en = (state == ST_CLK);

  afr_sck_gen #(.HALF(HALF), .NPULSE(NB)) u_sck (
    .clk(clk), .rst_n(rst_n), .en(clk_en),
    .sck_o(sck), .rise_o(rise), .done_o(done)
  );

  afr_shift #(.W(KW)) u_shift (
    .clk(clk), .rst_n(rst_n), .cap(rise), .din(sdo), .q(keep)
  );

  afr_tmo #(.LIMIT(TMO_CYC)) u_tmo (
    .clk(clk), .rst_n(rst_n), .run(state == ST_WAIT && sdo), .expire_o(tmo_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cs_q   <= 1'b1;
      err_q  <= 1'b0;
      sign_q <= 1'b0;
      ovr_q  <= 1'b0;
      data_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          cs_q  <= 1'b0;
          err_q <= 1'b0;
          state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (!sdo) begin
            state <= ST_CLK;
          end else if (tmo_exp) begin
            cs_q  <= 1'b1;
            err_q <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_CLK: if (done) begin
          cs_q   <= 1'b1;
          data_q <= keep[DW-1:0];
          sign_q <= keep[DW];
          ovr_q  <= (keep[DW] && (&keep[DW-1:0])) || (!keep[DW] && !(|keep[DW-1:0]));
          state  <= ST_HOLD;
        end
        ST_HOLD: if (res_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cs_n        = cs_q;
  assign timeout_err = err_q;
  assign conv_busy   = (state == ST_WAIT) && sdo;
  assign res_valid   = (state == ST_HOLD);
  assign res_data    = data_q;
  assign res_sign    = sign_q;
  assign res_ovr     = ovr_q;
endmodule

// File: rtl/afr_chk.sv
module afr_chk #(
  parameter int DW     = 16,
  parameter int NPULSE = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          cs_n,
  input logic          sck,
  input logic          conv_busy,
  input logic          timeout_err,
  input logic          res_valid,
  input logic          res_ready,
  input logic [DW-1:0] res_data,
  input logic          res_sign,
  input logic          res_ovr
);
  localparam int NW = $clog2(NPULSE + 2) + 1;
  logic          sck_d;
  logic [NW-1:0] nr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      nr    <= '0;
    end else begin
      sck_d <= sck;
      if (cs_n)              nr <= '0;
      else if (sck && !sck_d) nr <= nr + 1'b1;
    end
  end

  // R12
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck);

  // R3
  wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) conv_busy |-> (!cs_n && !sck));

  // R4
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cs_n) && !timeout_err) |-> (nr == NW'(NPULSE)));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_sign) && $stable(res_ovr)));

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready && start) |=> cs_n);

  // R11
  tmo_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> (cs_n && !res_valid));
endmodule

bind adc_frame_reader afr_chk #(.DW(DW), .NPULSE(DW + 3)) u_afr_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cs_n(cs_n), .sck(sck),
  .conv_busy(conv_busy), .timeout_err(timeout_err), .res_valid(res_valid),
  .res_ready(res_ready), .res_data(res_data), .res_sign(res_sign), .res_ovr(res_ovr)
);

// File: tb/adc_frame_reader_bench.sv
`timescale 1ns/1ps
module adc_frame_reader_bench;
  localparam int HALF = 3;
  localparam int TMO  = 300;
  localparam int DW   = 16;
  localparam int NB   = DW + 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, res_ready = 1'b0;
  logic cs_n, sck, sdo, conv_busy, timeout_err, res_valid, res_sign, res_ovr;
  logic [DW-1:0] res_data;

  adc_frame_reader #(.HALF(HALF), .TMO_CYC(TMO), .DW(DW)) u_adc_frame_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .cs_n(cs_n), .sck(sck), .sdo(sdo),
    .conv_busy(conv_busy), .timeout_err(timeout_err), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .res_sign(res_sign), .res_ovr(res_ovr)
  );

  int total = 0, bad = 0;

  // converter model: data changes on falling sck, low level means ready
  logic [NB-1:0] nxt_frame, m_frame = '0;
  int nxt_delay = 0, m_left = 0, m_idx = NB - 1;
  logic arm = 1'b0, arm_d = 1'b0, m_sck_d = 1'b0;
  int rises = 0, busy_edges = 0, phase_bad = 0, run_len = 0;

  always @(negedge clk) begin
    m_sck_d <= sck;
    if (m_left > 0) m_left <= m_left - 1;
    if (cs_n) m_idx <= NB - 1;
    else if (m_sck_d && !sck && m_left == 0 && m_idx > 0) m_idx <= m_idx - 1;
    if (sck && !m_sck_d) rises <= rises + 1;
    if (sck != m_sck_d && m_left > 0) busy_edges <= busy_edges + 1;
    if (sck != m_sck_d) begin
      if ((m_sck_d || rises > 0) && run_len != HALF) phase_bad <= phase_bad + 1;
      run_len <= 1;
    end else begin
      run_len <= run_len + 1;
    end
    if (arm != arm_d) begin
      arm_d      <= arm;
      m_frame    <= nxt_frame;
      m_left     <= nxt_delay;
      rises      <= 0;
      busy_edges <= 0;
      phase_bad  <= 0;
    end
  end

  assign sdo = cs_n ? 1'b1 : ((m_left > 0) ? 1'b1 : m_frame[m_idx]);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_ovr(input bit s, input logic [DW-1:0] d);
    return (s && d == {DW{1'b1}}) || (!s && d == '0);
  endfunction

  task automatic run_frame(input bit s, input logic [DW-1:0] d, input bit dummy,
                           input int delay, input int hold);
    int n;
    bit expect_tmo;
    logic [DW-1:0] held;
    expect_tmo = (delay > TMO + 20);
    nxt_frame = {1'b0, dummy, s, d};
    nxt_delay = delay;
    arm = ~arm;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(cs_n == 1'b0, "R2", "cs_n after start", cs_n, 0);
    chk(timeout_err == 1'b0, "R11", "err cleared by start", timeout_err, 0);
    if (delay >= 8) begin
      repeat (4) @(negedge clk);
      chk(conv_busy == 1'b1, "R2", "conv_busy while waiting", conv_busy, 1);
      chk(sck == 1'b0, "R3", "sck idle while waiting", sck, 0);
    end
    n = 0;
    while (!res_valid && !timeout_err && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (expect_tmo) begin
      chk(timeout_err == 1'b1, "R11", "timeout flag", timeout_err, 1);
      chk(res_valid == 1'b0 && cs_n == 1'b1, "R11", "released without result",
          {res_valid, cs_n}, 2'b01);
      chk(rises == 0, "R3", "no sck during timeout wait", rises, 0);
      return;
    end
    chk(res_valid == 1'b1, "R7", "result offered", res_valid, 1);
    chk(cs_n == 1'b1 && sck == 1'b0, "R7", "cs high sck low at result", {cs_n, sck}, 2'b10);
    chk(res_data == d, "R5", "data", res_data, d);
    chk(res_sign == s, "R5", "sign", res_sign, s);
    chk(res_ovr == exp_ovr(s, d), "R10", "overrange", res_ovr, exp_ovr(s, d));
    chk(rises == NB, "R4", "rising edges", rises, NB);
    chk(busy_edges == 0, "R3", "sck edges during conversion", busy_edges, 0);
    chk(phase_bad == 0, "R6", "phase length errors", phase_bad, 0);
    held = res_data;
    res_ready = 1'b0;
    for (int i = 0; i < hold; i++) begin
      start = (i == 1);
      @(negedge clk);
    end
    start = 1'b0;
    if (hold > 0) begin
      chk(res_valid == 1'b1 && res_data == held, "R8", "held under back-pressure",
          res_data, held);
      chk(cs_n == 1'b1, "R9", "start ignored while result waits", cs_n, 1);
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(res_valid == 1'b0, "R8", "valid drops after accept", res_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && sck == 1'b0, "R1", "cs/sck in reset", {cs_n, sck}, 2'b10);
    chk(res_valid == 1'b0 && timeout_err == 1'b0 && conv_busy == 1'b0, "R1",
        "flags in reset", {res_valid, timeout_err, conv_busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 1'b1 && sck == 1'b0, "R12", "idle after reset", {cs_n, sck}, 2'b10);

    run_frame(1'b1, 16'hFFFF, 1'b0, 10, 3);
    run_frame(1'b0, 16'h0000, 1'b1, 0, 0);
    run_frame(1'b1, 16'h0000, 1'b1, 20, 2);
    run_frame(1'b0, 16'hFFFF, 1'b0, 5, 0);
    run_frame(1'b1, 16'h8001, 1'b1, TMO - 40, 1);
    run_frame(1'b0, 16'h1234, 1'b0, TMO + 200, 0);
    run_frame(1'b1, 16'h5A5A, 1'b1, 12, 4);

    for (int k = 0; k < 30; k++) begin
      run_frame(1'($urandom), 16'($urandom), 1'($urandom),
                int'($urandom % 120), int'($urandom % 6));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule